// File: doc/BRIEF.md
# GPIO Pin Interrupt Control Register

The block is one 8-bit control and status register, plus the interrupt logic behind it, for a single general-purpose input pin. A processor writes the register through a plain port: a write strobe and a data byte, with the register visible at all times on a read-data byte. The written fields select the sense polarity, edge or level detection, an interrupt enable and a 3-bit request priority. A status bit, which the processor cannot write, records whether the pin condition has been seen.

The pin is asynchronous to the clock. It passes through a synchroniser before detection. In level mode the status bit tracks the pin after the polarity inversion. In edge mode a qualifying transition sets the status bit, and it stays set until software clears it with a write-one strobe. The interrupt request goes out with the programmed level, so that an external arbiter can rank it.

A change of polarity in edge mode can look like a transition. A switch from level to edge mode can carry a level-derived status into sticky storage. Software avoids both by setting the clear strobe in the same write.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register field is 0, rd_data_o reads 0x00 and irq_o is low.
- R2: The byte layout is bit 7 polarity, bit 6 mode (1 = edge, 0 = level), bit 5 status, bit 4 enable, bit 3 clear strobe, bits 2..0 level. Polarity, mode, enable and level read back as written. Bit 3 always reads 0. A write to bit 5 is ignored.
- R3: In level mode with polarity 0, the status bit equals the pin delayed by the synchroniser. A pin change is visible in status on the third rising clock edge after it.
- R4: In level mode with polarity 1, the status bit equals the inverted synchronised pin.
- R5: In edge mode with polarity 0, a rising transition of the synchronised pin sets status. Status then stays set when the pin falls.
- R6: In edge mode with polarity 1, a falling transition sets status, and a rising one does not.
- R7: In edge mode, a write with bit 3 set clears status. When a qualifying edge arrives in the same cycle as that write, the clear wins.
- R8: In level mode, bit 3 has no effect, and status keeps tracking the pin.
- R9: A polarity change written while edge mode is selected counts as an edge when it inverts the sensed value from 0 to 1. If the same write sets bit 3, status stays 0.
- R10: irq_o is high exactly when enable, status and a nonzero level are all present. irq_level_o always shows the programmed level.
- R11: A write that switches from level to edge mode keeps a status of 1, unless bit 3 is set in that write, in which case status becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| pin_i | input | 1 | Asynchronous general-purpose input pin |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Programmed request level |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same clock cycle as a synchronised edge. The edge only becomes visible two clock edges after the pin moves. The bench changes the pin, counts two rising edges, and then drives the clear write so that both events meet at the third edge. The spurious-edge cases come from a vector table that first settles the pin low in edge mode and then flips the polarity, once with the clear strobe in that write and once without it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned DATA_W = LVL_W + 5;
  // Bit positions fixed by the register layout
  localparam int unsigned POL_B  = DATA_W - 1;
  localparam int unsigned MODE_B = DATA_W - 2;
  localparam int unsigned STAT_B = DATA_W - 3;
  localparam int unsigned IEN_B  = DATA_W - 4;
  localparam int unsigned CLR_B  = DATA_W - 5;

  typedef struct packed {
    logic             pol;
    logic             edge_mode;
    logic             ien;
    logic [LVL_W-1:0] lvl;
  } cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,      // synchronised pin
  input  logic pol_eff_i,   // polarity in force this cycle
  input  logic edge_eff_i,  // edge mode in force this cycle
  input  logic clr_i,       // clear strobe written this cycle
  output logic status_o
);
  logic sensed, sensed_prev_q, edge_hit, status_q;

  assign sensed   = sync_i ^ pol_eff_i;
  // prev holds the value sensed under the polarity of its own cycle,
  // so a polarity flip can register as an edge
  assign edge_hit = sensed & ~sensed_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sensed_prev_q <= 1'b0;
      status_q      <= 1'b0;
    end else begin
      sensed_prev_q <= sensed;
      if (!edge_eff_i)   status_q <= sensed;
      else if (clr_i)    status_q <= 1'b0;
      else if (edge_hit) status_q <= 1'b1;
    end
  end

  assign status_o = status_q;

  p_clear_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_eff_i && clr_i) |=> !status_o);

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_eff_i && !clr_i && status_o) |=> status_o);

  p_level_track_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_eff_i |=> (status_o == ($past(sync_i) ^ $past(pol_eff_i))));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              pin_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  cfg_t cfg_q;
  logic pin_sync, status, pol_eff, edge_eff, clr_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      cfg_q.pol       <= wr_data_i[POL_B];
      cfg_q.edge_mode <= wr_data_i[MODE_B];
      cfg_q.ien       <= wr_data_i[IEN_B];
      cfg_q.lvl       <= wr_data_i[LVL_W-1:0];
    end
  end

  // A write's new mode and polarity govern detection in its own cycle
  assign pol_eff  = wr_en_i ? wr_data_i[POL_B]  : cfg_q.pol;
  assign edge_eff = wr_en_i ? wr_data_i[MODE_B] : cfg_q.edge_mode;
  assign clr_wr   = wr_en_i & wr_data_i[CLR_B];

  gpio_irq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_irq_detect i_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (pin_sync),
    .pol_eff_i  (pol_eff),
    .edge_eff_i (edge_eff),
    .clr_i      (clr_wr),
    .status_o   (status)
  );

  assign rd_data_o   = {cfg_q.pol, cfg_q.edge_mode, status, cfg_q.ien, 1'b0, cfg_q.lvl};
  assign irq_level_o = cfg_q.lvl;
  assign irq_o       = cfg_q.ien & status & (|cfg_q.lvl);

  p_lvl_zero_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o == '0) |-> !irq_o);

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(rd_data_o[POL_B:MODE_B]) && $stable(irq_level_o)));

  p_clr_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !rd_data_o[CLR_B]);
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] req;
    logic       do_wr;
    logic [7:0] wd;
    logic       pin;
    logic [7:0] exp_rd;
    logic       exp_irq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b1, 8'h17, 1'b0, 8'h17, 1'b0}, // R2 level pol0 ien lvl7
    '{4'd3,  1'b0, 8'h00, 1'b1, 8'h37, 1'b1}, // R3 pin high
    '{4'd3,  1'b0, 8'h00, 1'b0, 8'h17, 1'b0}, // R3 pin low
    '{4'd4,  1'b1, 8'h90, 1'b0, 8'hB0, 1'b0}, // R4 inverted, R10 lvl0 quiet
    '{4'd4,  1'b0, 8'h00, 1'b1, 8'h90, 1'b0}, // R4
    '{4'd8,  1'b1, 8'h3D, 1'b1, 8'h35, 1'b1}, // R8 clear ignored in level
    '{4'd3,  1'b0, 8'h00, 1'b0, 8'h15, 1'b0}, // R3
    '{4'd2,  1'b1, 8'h35, 1'b0, 8'h15, 1'b0}, // R2 status write ignored
    '{4'd5,  1'b1, 8'h52, 1'b0, 8'h52, 1'b0}, // R5 enter edge mode
    '{4'd5,  1'b0, 8'h00, 1'b1, 8'h72, 1'b1}, // R5 rising sets
    '{4'd5,  1'b0, 8'h00, 1'b0, 8'h72, 1'b1}, // R5 sticky
    '{4'd7,  1'b1, 8'h5A, 1'b0, 8'h52, 1'b0}, // R7 clear
    '{4'd10, 1'b1, 8'h42, 1'b1, 8'h62, 1'b0}, // R10 enable off
    '{4'd7,  1'b1, 8'h4A, 1'b1, 8'h42, 1'b0}, // R7 clear
    '{4'd5,  1'b0, 8'h00, 1'b0, 8'h42, 1'b0}, // R5 falling ignored
    '{4'd9,  1'b1, 8'hCA, 1'b0, 8'hC2, 1'b0}, // R9 pol flip with clear
    '{4'd6,  1'b0, 8'h00, 1'b1, 8'hC2, 1'b0}, // R6 rising ignored
    '{4'd6,  1'b0, 8'h00, 1'b0, 8'hE2, 1'b0}, // R6 falling sets
    '{4'd7,  1'b1, 8'hCA, 1'b0, 8'hC2, 1'b0}, // R7
    '{4'd9,  1'b1, 8'h4A, 1'b0, 8'h42, 1'b0}, // R9 flip back
    '{4'd9,  1'b1, 8'hC2, 1'b0, 8'hE2, 1'b0}, // R9 flip without clear
    '{4'd3,  1'b1, 8'h00, 1'b1, 8'h20, 1'b0}, // R3 level, pin high
    '{4'd11, 1'b1, 8'h40, 1'b1, 8'h60, 1'b0}, // R11 status kept
    '{4'd3,  1'b1, 8'h00, 1'b1, 8'h20, 1'b0}, // R3
    '{4'd11, 1'b1, 8'h48, 1'b1, 8'h40, 1'b0}  // R11 clear on switch
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       pin_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o;
  logic [2:0] irq_level_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .pin_i       (pin_i),
    .irq_o       (irq_o),
    .irq_level_o (irq_level_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 rd", rd_data_o, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rd after release", rd_data_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
      pin_i     = VECS[i].pin;
      wr_en_i   = VECS[i].do_wr;
      wr_data_i = VECS[i].wd;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      repeat (2) @(negedge clk_i);
      chk({tag, " rd"}, rd_data_o, VECS[i].exp_rd);
      chk({tag, " irq"}, {7'd0, irq_o}, {7'd0, VECS[i].exp_irq});
      chk({tag, " lvl"}, {5'd0, irq_level_o}, {5'd0, VECS[i].exp_rd[2:0]});
    end

    // R7: clear write meeting a synchronised edge in the same cycle
    wr_en_i = 1'b1; wr_data_i = 8'h51; pin_i = 1'b0;
    @(negedge clk_i); wr_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R7 setup", rd_data_o, 8'h51);
    pin_i = 1'b1;
    repeat (2) @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = 8'h59;
    @(negedge clk_i); wr_en_i = 1'b0;
    chk("R7 clear beats edge", rd_data_o, 8'h51);
    repeat (3) @(negedge clk_i);
    chk("R7 stays clear", rd_data_o, 8'h51);

    // R1: reset mid-run returns every field to zero
    pin_i = 1'b0;
    wr_en_i = 1'b1; wr_data_i = 8'hD7;
    @(negedge clk_i); wr_en_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R1 mid-run reset", rd_data_o, 8'h00);
    chk("R1 mid-run irq", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule